// File: doc/BRIEF.md
# Host Byte Port with Command and Report Latches

This block is the device side of an 8-bit parallel host interface. The host writes command bytes with an active-low write strobe and reads report bytes with an active-low read strobe. Both strobes are asynchronous to the device clock. The block holds one command byte and one report byte, and each latch has a handshake flag that the host can see.

On the device side, commands leave as a valid/ready stream. `cmd_valid` stays high with `cmd_data` held stable until `cmd_ready` is seen high at a clock edge. Reports enter as a valid/ready stream of a channel field and a tone field. `rpt_ready` is held high: the port never stalls the poster, and a report that finds the latch still unread is dropped and noted in a sticky overrun bit.

Each strobe passes through a two-flop synchronizer. Edges are detected in the device clock domain. The bus drive enable opens on a detected read fall and closes on a detected read rise. After reset a report byte of 00 hex is already posted, which tells the host that the device is alive.

Top module: `hbp_port`

## Requirements
- R1: During and right after reset, the port is in the following state. `host_cmd_busy` is 0 and `cmd_valid` is 0. `host_rpt_full_n` is 0 and the posted report byte is 00 hex. `host_bus_oe` is 0, `host_bus_o` is 0, `rpt_overrun` is 0 and `rpt_ready` is 1.
- R2: `host_cmd_busy` goes to 1 three clock cycles after `host_wr_n` falls.
- R3: When `host_wr_n` rises, the byte present on `host_bus_i` while the strobe was low is taken into the command latch. `cmd_valid` rises three cycles after the strobe rises. `cmd_data` holds the byte, unchanged, while `cmd_valid` is 1 and `cmd_ready` is 0.
- R4: `host_cmd_busy` returns to 0 the cycle after a `cmd_valid`/`cmd_ready` handshake, unless a write strobe is then in progress. It stays at 1 while the write strobe is low, even if the latch has been emptied.
- R5: A write that completes while the previous command is still unconsumed is dropped. The older byte stays in `cmd_data`, and the busy flag stays at 1 until that byte is consumed.
- R6: A report posted with `rpt_valid` drives `host_rpt_full_n` to 0 one cycle later. The report byte carries `rpt_chan` in its upper 3 bits (bits 7:5) and `rpt_tone` in its lower 5 bits (bits 4:0).
- R7: Three cycles after `host_rd_n` falls, `host_rpt_full_n` returns to 1 and `host_bus_oe` goes to 1, with the report byte on `host_bus_o`. Three cycles after `host_rd_n` rises, `host_bus_oe` is 0. While `host_bus_oe` is 0, `host_bus_o` is 0. The driven byte does not change during one read.
- R8: A report posted while the latch holds an unread byte, with no read falling in that cycle, is dropped. The older byte is kept and `rpt_overrun` is set. `rpt_overrun` stays at 1 until reset.
- R9: If a report is posted in the same cycle that a read fall is detected, the read returns the older byte and the new byte is accepted. `host_rpt_full_n` then stays at 0 and no overrun is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_bus_i | input | 8 | Host data bus, sampled during writes |
| host_bus_o | output | 8 | Report byte driven to the host, 0 when not driving |
| host_bus_oe | output | 1 | Bus drive enable toward the host |
| host_cmd_busy | output | 1 | Command latch busy flag, high from write start until consumed |
| host_rpt_full_n | output | 1 | Report latch full flag, active low |
| cmd_valid | output | 1 | Command byte available to the device |
| cmd_ready | input | 1 | Device accepts the command byte |
| cmd_data | output | 8 | Command byte |
| rpt_valid | input | 1 | Device posts a report |
| rpt_ready | output | 1 | Always 1; reports are never stalled |
| rpt_chan | input | 3 | Channel on which the tone arrived |
| rpt_tone | input | 5 | Received tone code |
| rpt_overrun | output | 1 | Sticky flag: a report was dropped |

## Verification
The host-side results come three cycles after the strobe edge that causes them. This covers the busy flag after a write fall, `cmd_valid` after a write rise, and the full flag and drive enable after either read edge. The device-side results come one cycle after the handshake or post. Each check waits exactly that number of rising edges from the falling edge where the stimulus was applied, and then samples on the next falling edge. The corner cases use the same counts so the collision lands on a known edge: the report posted on the same edge as a detected read fall, and the command consumed while a new write strobe is still low.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  // Edge events of one synchronized active-low strobe, in the clock domain.
  typedef struct packed {
    logic fall;
    logic rise;
  } hbp_edge_t;
endpackage

// File: rtl/hbp_sync_edge.sv
module hbp_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  output hbp_pkg::hbp_edge_t edges
);
  // STAGES synchronizer flops plus one history flop for edge detection.
  localparam int unsigned CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  // Strobes idle high, so the chain resets high and no edge is seen at reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[CHAIN-2:0], strobe_n};
  end

  always_comb begin
    edges.fall = chain_q[STAGES] & ~chain_q[STAGES-1];
    edges.rise = ~chain_q[STAGES] & chain_q[STAGES-1];
  end
endmodule

// File: rtl/hbp_bus_pipe.sv
module hbp_bus_pipe #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out
);
  // Delays the bus by as many flops as the strobe passes through. When a
  // rise is detected, the output therefore shows the bus from the last
  // sample at which the strobe was still low.
  logic [W-1:0] stage_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[k] <= '0;
      else if (k == 0) stage_q[k] <= bus_in;
      else             stage_q[k] <= stage_q[(k == 0) ? 0 : k-1];
    end
  end

  assign bus_out = stage_q[DEPTH-1];
endmodule

// File: rtl/hbp_cmd_latch.sv
module hbp_cmd_latch #(
  parameter int unsigned W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  hbp_pkg::hbp_edge_t wr,
  input  logic [W-1:0]       bus_aligned,
  input  logic               cmd_ready,
  output logic               cmd_valid,
  output logic [W-1:0]       cmd_data,
  output logic               busy
);
  logic         open_q;   // write strobe seen low, rise not yet seen
  logic         valid_q;
  logic         busy_q;
  logic [W-1:0] data_q;

  logic open_d;
  logic valid_keep;
  logic take;

  always_comb begin
    open_d = open_q;
    if (wr.fall)      open_d = 1'b1;
    else if (wr.rise) open_d = 1'b0;
    // A byte survives this edge only if it is not handed over now.
    valid_keep = valid_q & ~cmd_ready;
    // A completed write is taken only into an empty latch; otherwise dropped.
    take = wr.rise & ~valid_keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      valid_q <= 1'b0;
      busy_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      open_q  <= open_d;
      valid_q <= valid_keep | take;
      busy_q  <= open_d | valid_keep | take;
      if (take) data_q <= bus_aligned;
    end
  end

  assign cmd_valid = valid_q;
  assign cmd_data  = data_q;
  assign busy      = busy_q;
endmodule

// File: rtl/hbp_rpt_latch.sv
module hbp_rpt_latch #(
  parameter int unsigned W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  hbp_pkg::hbp_edge_t rd,
  input  logic               post_valid,
  input  logic [W-1:0]       post_byte,
  output logic               full_n,
  output logic [W-1:0]       bus_o,
  output logic               bus_oe,
  output logic               overrun
);
  logic         full_q;    // unread byte present (active high inside)
  logic [W-1:0] byte_q;    // latched report
  logic [W-1:0] shown_q;   // byte frozen for the current read window
  logic         oe_q;
  logic         ovr_q;

  logic room;
  logic accept;
  logic drop;

  always_comb begin
    // A read fall empties the latch in the same edge, so a post can follow.
    room   = ~full_q | rd.fall;
    accept = post_valid & room;
    drop   = post_valid & ~room;
  end

  // Reset leaves a 00 byte posted: the alive report.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b1;
      byte_q  <= '0;
      shown_q <= '0;
      oe_q    <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (rd.fall) shown_q <= byte_q;
      if (accept)  byte_q  <= post_byte;
      full_q <= accept | (full_q & ~rd.fall);
      if (rd.fall)      oe_q <= 1'b1;
      else if (rd.rise) oe_q <= 1'b0;
      if (drop) ovr_q <= 1'b1;
    end
  end

  assign full_n  = ~full_q;
  assign bus_oe  = oe_q;
  assign bus_o   = oe_q ? shown_q : '0;
  assign overrun = ovr_q;
endmodule

// File: rtl/hbp_port.sv
module hbp_port #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned CHAN_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_wr_n,
  input  logic                       host_rd_n,
  input  logic [BYTE_W-1:0]          host_bus_i,
  output logic [BYTE_W-1:0]          host_bus_o,
  output logic                       host_bus_oe,
  output logic                       host_cmd_busy,
  output logic                       host_rpt_full_n,
  output logic                       cmd_valid,
  input  logic                       cmd_ready,
  output logic [BYTE_W-1:0]          cmd_data,
  input  logic                       rpt_valid,
  output logic                       rpt_ready,
  input  logic [CHAN_W-1:0]          rpt_chan,
  input  logic [BYTE_W-CHAN_W-1:0]   rpt_tone,
  output logic                       rpt_overrun
);
  localparam int unsigned TONE_W     = BYTE_W - CHAN_W;
  localparam int unsigned PIPE_DEPTH = SYNC_STAGES + 1;

  hbp_pkg::hbp_edge_t wr_edges;
  hbp_pkg::hbp_edge_t rd_edges;
  logic [BYTE_W-1:0]  bus_aligned;
  logic [BYTE_W-1:0]  post_byte;

  hbp_sync_edge #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(host_wr_n), .edges(wr_edges)
  );

  hbp_sync_edge #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(host_rd_n), .edges(rd_edges)
  );

  hbp_bus_pipe #(.W(BYTE_W), .DEPTH(PIPE_DEPTH)) u_bus_pipe (
    .clk(clk), .rst_n(rst_n), .bus_in(host_bus_i), .bus_out(bus_aligned)
  );

  hbp_cmd_latch #(.W(BYTE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(wr_edges), .bus_aligned(bus_aligned),
    .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .busy(host_cmd_busy)
  );

  // Channel in the upper field, tone code in the lower field.
  assign post_byte = {rpt_chan, rpt_tone[TONE_W-1:0]};

  hbp_rpt_latch #(.W(BYTE_W)) u_rpt (
    .clk(clk), .rst_n(rst_n), .rd(rd_edges), .post_valid(rpt_valid),
    .post_byte(post_byte), .full_n(host_rpt_full_n), .bus_o(host_bus_o),
    .bus_oe(host_bus_oe), .overrun(rpt_overrun)
  );

  // Reports are never stalled; a report that finds the latch full is dropped.
  assign rpt_ready = 1'b1;
endmodule

// File: rtl/hbp_port_chk.sv
module hbp_port_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [BYTE_W-1:0] cmd_data,
  input logic              host_cmd_busy,
  input logic              host_bus_oe,
  input logic [BYTE_W-1:0] host_bus_o,
  input logic              host_rpt_full_n,
  input logic              rpt_valid,
  input logic              rpt_overrun
);
  // R3: a stalled command stays offered and unchanged
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

  // R4: an unconsumed command always shows as busy to the host
  assert_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> host_cmd_busy);

  // R6: any post leaves the full flag asserted
  assert_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |=> !host_rpt_full_n);

  // R7: driven byte does not change inside one read window
  assert_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_bus_oe && $past(host_bus_oe) |-> $stable(host_bus_o));

  // R8: overrun is sticky
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_overrun |=> rpt_overrun);
endmodule

bind hbp_port hbp_port_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .host_cmd_busy(host_cmd_busy), .host_bus_oe(host_bus_oe),
  .host_bus_o(host_bus_o), .host_rpt_full_n(host_rpt_full_n),
  .rpt_valid(rpt_valid), .rpt_overrun(rpt_overrun)
);

// File: tb/sim_hbp_port.sv
module sim_hbp_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr_n, host_rd_n;
  logic [7:0] host_bus_i, host_bus_o;
  logic       host_bus_oe, host_cmd_busy, host_rpt_full_n;
  logic       cmd_valid, cmd_ready;
  logic [7:0] cmd_data;
  logic       rpt_valid, rpt_ready;
  logic [2:0] rpt_chan;
  logic [4:0] rpt_tone;
  logic       rpt_overrun;

  always #10 clk = ~clk;  // 50 MHz

  hbp_port u0 (.*);

  int total = 0;
  int fails = 0;
  logic [7:0] cmd_q[$];
  logic [7:0] rpt_q[$];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: write strobe low with byte b; expected byte queued when it should land.
  task automatic wr_begin(input logic [7:0] b, input bit expect_take);
    host_bus_i = b;
    host_wr_n  = 1'b0;
    if (expect_take) cmd_q.push_back(b);
    tick(3);
  endtask

  task automatic wr_end();
    host_wr_n  = 1'b1;
    host_bus_i = ~host_bus_i;   // bus changes with the rising strobe
    tick(3);
  endtask

  task automatic consume();
    cmd_ready = 1'b1;
    tick(1);
    cmd_ready = 1'b0;
  endtask

  task automatic post(input logic [2:0] c, input logic [4:0] t, input bit expect_take);
    rpt_chan  = c;
    rpt_tone  = t;
    rpt_valid = 1'b1;
    if (expect_take) rpt_q.push_back({c, t});
    tick(1);
    rpt_valid = 1'b0;
  endtask

  task automatic host_read();
    logic [7:0] exp;
    exp = (rpt_q.size() != 0) ? rpt_q.pop_front() : 8'h00;
    host_rd_n = 1'b0;
    tick(3);
    chk("R7 full flag released by read", host_rpt_full_n, 1);
    chk("R7 drive enable on", host_bus_oe, 1);
    chk("R7 report byte on bus", host_bus_o, exp);
    host_rd_n = 1'b1;
    tick(3);
    chk("R7 drive enable off", host_bus_oe, 0);
    chk("R7 bus quiet", host_bus_o, 0);
  endtask

  // Monitor: scoreboard for the command stream.
  always @(negedge clk) begin
    #1;
    if (rst_n && cmd_valid && cmd_ready) begin
      if (cmd_q.size() == 0) begin
        total++;
        fails++;
        $display("FAIL R5 unexpected command actual=%0h expected=none", cmd_data);
      end else begin
        chk("R3 command byte", cmd_data, cmd_q.pop_front());
      end
    end
  end

  initial begin
    host_wr_n = 1'b1; host_rd_n = 1'b1; host_bus_i = 8'h00;
    cmd_ready = 1'b0; rpt_valid = 1'b0; rpt_chan = '0; rpt_tone = '0;
    rpt_q.push_back(8'h00);   // alive byte
    tick(4);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 busy", host_cmd_busy, 0);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 full_n", host_rpt_full_n, 0);
    chk("R1 bus_oe", host_bus_oe, 0);
    chk("R1 overrun", rpt_overrun, 0);
    chk("R1 rpt_ready", rpt_ready, 1);
    host_read();              // R1 alive byte 00

    // R2 / R3 basic write
    wr_begin(8'h5A, 1);
    chk("R2 busy after write fall", host_cmd_busy, 1);
    chk("R3 no command before rise", cmd_valid, 0);
    wr_end();
    chk("R3 cmd_valid after rise", cmd_valid, 1);
    chk("R3 captured byte", cmd_data, 8'h5A);
    tick(2);
    chk("R3 held while stalled", cmd_data, 8'h5A);
    consume();
    chk("R4 busy clears after handshake", host_cmd_busy, 0);
    chk("R4 valid clears after handshake", cmd_valid, 0);

    // R5 second write dropped while first unconsumed
    wr_begin(8'h3C, 1); wr_end();
    wr_begin(8'hC3, 0); wr_end();
    chk("R5 busy still set", host_cmd_busy, 1);
    chk("R5 older byte kept", cmd_data, 8'h3C);
    consume();
    chk("R5 busy clears", host_cmd_busy, 0);

    // R4 busy held while strobe low after consumption
    wr_begin(8'h11, 1); wr_end();
    wr_begin(8'h22, 1);
    consume();
    chk("R4 busy held during strobe", host_cmd_busy, 1);
    chk("R4 latch empty", cmd_valid, 0);
    wr_end();
    chk("R4 new byte taken", cmd_data, 8'h22);
    consume();
    chk("R4 busy clears at end", host_cmd_busy, 0);

    // R6 field positions
    post(3'd5, 5'h13, 1);
    chk("R6 full_n low after post", host_rpt_full_n, 0);
    host_read();              // expects 8'hB3

    // R8 overrun
    post(3'd2, 5'h07, 1);
    post(3'd6, 5'h01, 0);
    chk("R8 overrun set", rpt_overrun, 1);
    chk("R8 still full", host_rpt_full_n, 0);
    host_read();              // older byte 8'h47
    chk("R8 overrun sticky", rpt_overrun, 1);

    // R9 post on the same edge as read fall detection
    post(3'd1, 5'h01, 1);     // 8'h21
    host_rd_n = 1'b0;
    tick(2);
    rpt_chan = 3'd7; rpt_tone = 5'h1F; rpt_valid = 1'b1;
    tick(1);
    rpt_valid = 1'b0;
    chk("R9 new byte accepted", host_rpt_full_n, 0);
    chk("R9 read shows older byte", host_bus_o, rpt_q.pop_front());
    chk("R9 drive enable", host_bus_oe, 1);
    rpt_q.push_back(8'hFF);
    host_rd_n = 1'b1;
    tick(3);
    chk("R7 drive off after read", host_bus_oe, 0);
    host_read();              // 8'hFF

    chk("R3 all commands seen", cmd_q.size(), 0);
    chk("R9 all reports read", rpt_q.size(), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule